// File: doc/BRIEF.md
# Vector Extended-Divide Execution Unit

This unit performs extended division on 128-bit vector operands over many cycles. Each dividend element is widened to twice its size: the source element becomes the upper half and the lower half is zero. The element of the second operand divides it, and the unit returns the low half of the quotient, one element's width.

A 32-bit instruction word picks one of four operations. There are two element widths. In 64-bit mode the unit runs two independent lanes. In 128-bit mode it runs one lane. Each width can be signed or unsigned. Signed division truncates toward zero. A lane whose divisor is zero, or a signed lane that divides the most negative value by minus one, returns its dividend element unchanged and runs no iterations.

The request side uses a valid/ready handshake:
- A request is taken on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is low for the whole time the unit is busy, so a request offered then stays waiting at the producer and does not disturb the operation in progress.
- The result side has no back-pressure. `done` is a one-cycle pulse, and `result` keeps its value until the next operation completes.

Top module: `vxdiv_unit`

## Requirements
- R1: Bits [31:26] of the word must be 6'b000100, and bits [10:0] must be one of 11'b01111001011 (signed 64), 11'b01011001011 (unsigned 64), 11'b01100001011 (signed 128) or 11'b01000001011 (unsigned 128). Any other word is accepted and ignored: busy stays low, no done pulse follows, and result does not change. Bits [25:11] have no effect.
- R2: Unsigned 64-bit mode has two lanes. Lane 0 covers bits [63:0] and lane 1 covers bits [127:64]. In lane i, the dividend {A_i, 64'b0} is divided by B_i, and the lane takes the low 64 bits of the quotient.
- R3: Signed 64-bit mode does the same division in two's complement, and the quotient truncates toward zero.
- R4: Unsigned 128-bit mode divides the dividend {A, 128'b0} by B and returns the low 128 bits of the quotient.
- R5: Signed 128-bit mode does the same division in two's complement, truncating toward zero.
- R6: A lane whose divisor element is zero returns its A element, in both signed and unsigned modes.
- R7: In signed mode, a lane whose A element is the most negative value of its width and whose B element is all ones returns its A element. In unsigned mode the same bit patterns are divided normally.
- R8: When the quotient does not fit in the element width, the lane returns the low element-width bits of the true quotient.
- R9: In 64-bit mode, a special case in one lane does not change the other lane's result.
- R10: The request is accepted at edge E0. `done` is high for exactly one cycle, after edge E129 in 64-bit mode and after edge E257 in 128-bit mode. When every lane is a special case, `done` comes after edge E1 instead.
- R11: `in_ready` equals not `busy`. `busy` is high from the edge after acceptance until `done` rises. A request offered while busy does not change the result in progress.
- R12: After reset, `busy` and `done` are low, `in_ready` is high and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Unit can accept a request |
| insn | input | 32 | Instruction word |
| opa | input | 128 | Dividend source vector |
| opb | input | 128 | Divisor vector |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: result updated |
| result | output | 128 | Quotient vector, held until next completion |

## Verification
The main function is tried with four kinds of operand:
- Small positive values, whose quotient fits in the element, show whether the shift-subtract core is correct.
- Large values whose quotient overflows show whether the low bits are kept as R8 requires.
- Mixed-sign operands separate truncation toward zero from flooring, and show whether the negation is applied to the right lanes.
- Special-case operands placed in only one lane show that the lanes are independent and that latency is taken from the slower lane.

Words that are not legal, and requests made while busy, check that nothing is disturbed.

// File: rtl/vxdiv_pkg.sv
package vxdiv_pkg;

  localparam logic [5:0]  PRIMARY_OPC = 6'b000100;
  localparam logic [10:0] XO_S_NARROW = 11'b01111001011;
  localparam logic [10:0] XO_U_NARROW = 11'b01011001011;
  localparam logic [10:0] XO_S_WIDE   = 11'b01100001011;
  localparam logic [10:0] XO_U_WIDE   = 11'b01000001011;

  typedef struct packed {
    logic legal;
    logic wide;
    logic sgn;
  } vx_op_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } vx_state_t;

endpackage

// File: rtl/vxdiv_decode.sv
module vxdiv_decode
  import vxdiv_pkg::*;
(
  input  logic [31:0] insn,
  output vx_op_t      op
);
  logic unused_fields;
  assign unused_fields = ^insn[25:11];

  always_comb begin
    op = '0;
    if (insn[31:26] == PRIMARY_OPC) begin
      unique case (insn[10:0])
        XO_S_NARROW: op = '{legal: 1'b1, wide: 1'b0, sgn: 1'b1};
        XO_U_NARROW: op = '{legal: 1'b1, wide: 1'b0, sgn: 1'b0};
        XO_S_WIDE:   op = '{legal: 1'b1, wide: 1'b1, sgn: 1'b1};
        XO_U_WIDE:   op = '{legal: 1'b1, wide: 1'b1, sgn: 1'b0};
        default:     op = '0;
      endcase
    end
  end
endmodule

// File: rtl/vxdiv_sign_prep.sv
module vxdiv_sign_prep #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sgn,
  output logic [W-1:0] mag_a,
  output logic [W-1:0] mag_b,
  output logic         neg,
  output logic         special
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic a_neg, b_neg;

  always_comb begin
    a_neg   = sgn & a[W-1];
    b_neg   = sgn & b[W-1];
    mag_a   = a_neg ? (~a + 1'b1) : a;
    mag_b   = b_neg ? (~b + 1'b1) : b;
    neg     = a_neg ^ b_neg;
    special = (b == '0) | (sgn & (a == MOST_NEG) & (b == '1));
  end
endmodule

// File: rtl/vxdiv_engine.sv
module vxdiv_engine #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         live,
  input  logic [W-1:0] dvd_top,
  input  logic [W-1:0] dvs_in,
  output logic [W-1:0] quot
);
  logic [W-1:0] sh_q, rem_q, dvs_q, q_q;
  logic         live_q;
  logic [W:0]   shifted, diff;
  logic         fits;

  always_comb begin
    shifted = {rem_q, sh_q[W-1]};
    diff    = shifted - {1'b0, dvs_q};
    fits    = ~diff[W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      q_q    <= '0;
      live_q <= 1'b0;
    end else if (load) begin
      sh_q   <= dvd_top;
      rem_q  <= '0;
      dvs_q  <= dvs_in;
      q_q    <= '0;
      live_q <= live;
    end else if (step && live_q) begin
      sh_q  <= {sh_q[W-2:0], 1'b0};
      rem_q <= fits ? diff[W-1:0] : shifted[W-1:0];
      q_q   <= {q_q[W-2:0], fits};
    end
  end

  assign quot = q_q;

  // R2 R4: restoring invariant, partial remainder stays below divisor
  assert_rem_below_dvs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && live_q) |-> (rem_q < dvs_q));

  // R6: a live lane never holds a zero divisor
  assert_live_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (dvs_q != '0));
endmodule

// File: rtl/vxdiv_unit.sv
module vxdiv_unit
  import vxdiv_pkg::*;
#(
  parameter int ELEM_W = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [31:0]           insn,
  input  logic [2*ELEM_W-1:0]   opa,
  input  logic [2*ELEM_W-1:0]   opb,
  output logic                  busy,
  output logic                  done,
  output logic [2*ELEM_W-1:0]   result
);
  localparam int VEC_W  = 2 * ELEM_W;
  localparam int NLANE  = VEC_W / ELEM_W;
  localparam int CNT_W  = $clog2(2 * VEC_W + 1);
  localparam logic [CNT_W-1:0] ITER_WIDE   = CNT_W'(2 * VEC_W);
  localparam logic [CNT_W-1:0] ITER_NARROW = CNT_W'(2 * ELEM_W);

  vx_op_t op;
  logic   accept, start;

  vxdiv_decode u_dec (.insn(insn), .op(op));

  assign accept = in_valid & in_ready;
  assign start  = accept & op.legal;

  // narrow lanes
  logic [ELEM_W-1:0] n_mag_a [NLANE];
  logic [ELEM_W-1:0] n_mag_b [NLANE];
  logic [NLANE-1:0]  n_neg, n_special;

  for (genvar g = 0; g < NLANE; g++) begin : g_nprep
    vxdiv_sign_prep #(.W(ELEM_W)) u_prep (
      .a(opa[g*ELEM_W +: ELEM_W]), .b(opb[g*ELEM_W +: ELEM_W]), .sgn(op.sgn),
      .mag_a(n_mag_a[g]), .mag_b(n_mag_b[g]),
      .neg(n_neg[g]), .special(n_special[g]));
  end

  // wide lane
  logic [VEC_W-1:0] w_mag_a, w_mag_b;
  logic             w_neg, w_special;

  vxdiv_sign_prep #(.W(VEC_W)) u_wprep (
    .a(opa), .b(opb), .sgn(op.sgn),
    .mag_a(w_mag_a), .mag_b(w_mag_b), .neg(w_neg), .special(w_special));

  // state
  vx_state_t        state;
  logic [CNT_W-1:0] cnt;
  logic             wide_q;
  logic [VEC_W-1:0] a_q;
  logic [NLANE-1:0] neg_q, spec_q;
  logic             all_spec;
  logic             step;

  assign all_spec = op.wide ? w_special : (&n_special);
  assign step     = (state == ST_RUN);

  // engine 0: full width, also carries narrow lane 0
  logic [VEC_W-1:0] e0_top, e0_dvs, q0;
  logic             e0_live;

  always_comb begin
    if (op.wide) begin
      e0_top  = w_mag_a;
      e0_dvs  = w_mag_b;
      e0_live = ~w_special;
    end else begin
      e0_top  = {n_mag_a[0], {ELEM_W{1'b0}}};
      e0_dvs  = {{ELEM_W{1'b0}}, n_mag_b[0]};
      e0_live = ~n_special[0];
    end
  end

  vxdiv_engine #(.W(VEC_W)) u_eng0 (
    .clk(clk), .rst_n(rst_n), .load(start), .step(step), .live(e0_live),
    .dvd_top(e0_top), .dvs_in(e0_dvs), .quot(q0));

  // engines for the remaining narrow lanes
  logic [ELEM_W-1:0] qn [NLANE];
  assign qn[0] = q0[ELEM_W-1:0];

  for (genvar g = 1; g < NLANE; g++) begin : g_neng
    vxdiv_engine #(.W(ELEM_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .load(start), .step(step),
      .live(~op.wide & ~n_special[g]),
      .dvd_top(n_mag_a[g]), .dvs_in(n_mag_b[g]), .quot(qn[g]));
  end

  // final sign and special-case selection
  logic [VEC_W-1:0] fin_val;

  always_comb begin
    if (wide_q) begin
      if (spec_q[0])     fin_val = a_q;
      else if (neg_q[0]) fin_val = ~q0 + 1'b1;
      else               fin_val = q0;
    end else begin
      for (int l = 0; l < NLANE; l++) begin
        if (spec_q[l])     fin_val[l*ELEM_W +: ELEM_W] = a_q[l*ELEM_W +: ELEM_W];
        else if (neg_q[l]) fin_val[l*ELEM_W +: ELEM_W] = ~qn[l] + 1'b1;
        else               fin_val[l*ELEM_W +: ELEM_W] = qn[l];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      wide_q <= 1'b0;
      a_q    <= '0;
      neg_q  <= '0;
      spec_q <= '0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            wide_q <= op.wide;
            a_q    <= opa;
            cnt    <= op.wide ? ITER_WIDE : ITER_NARROW;
            if (op.wide) begin
              neg_q  <= {{(NLANE-1){1'b0}}, w_neg};
              spec_q <= {{(NLANE-1){1'b1}}, w_special};
            end else begin
              neg_q  <= n_neg;
              spec_q <= n_special;
            end
            state <= all_spec ? ST_FIN : ST_RUN;
          end
        end
        ST_RUN: begin
          cnt <= cnt - 1'b1;
          if (cnt == CNT_W'(1)) state <= ST_FIN;
        end
        ST_FIN: begin
          result <= fin_val;
          done   <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign in_ready = ~busy;

  // R11: a legal accepted request makes the unit busy
  assert_accept_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R1: an illegal word leaves the unit idle with no completion
  assert_illegal_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !op.legal) |=> (!busy && !done));

  // R10: done is a single-cycle pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: iteration phase never runs with an exhausted counter
  assert_run_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> (cnt != '0));

  // R11: result holds between completions
  assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  // R11: completion coincides with return to idle
  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/test_vxdiv_unit.sv
`timescale 1ns/1ps
module test_vxdiv_unit;
  localparam logic [10:0] C_S64  = 11'b01111001011;
  localparam logic [10:0] C_U64  = 11'b01011001011;
  localparam logic [10:0] C_S128 = 11'b01100001011;
  localparam logic [10:0] C_U128 = 11'b01000001011;
  localparam logic [63:0]  MIN64  = 64'h8000_0000_0000_0000;
  localparam logic [127:0] MIN128 = {64'h8000_0000_0000_0000, 64'h0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready, busy, done;
  logic [31:0]  insn = '0;
  logic [127:0] opa = '0, opb = '0, result;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  vxdiv_unit i_vxdiv_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .insn(insn), .opa(opa), .opb(opb), .busy(busy), .done(done), .result(result));

  function automatic logic [31:0] mk(input logic [10:0] c);
    return {6'b000100, 5'd3, 5'd4, 5'd5, c};
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference: value and latency (edges after accept before done edge)
  function automatic logic [127:0] model(input logic [31:0] w, input logic [127:0] a,
                                         input logic [127:0] b, output int lat);
    bit sg, wide;
    logic [127:0] r;
    sg   = (w[10:0] == C_S64) || (w[10:0] == C_S128);
    wide = (w[10:0] == C_S128) || (w[10:0] == C_U128);
    r = '0;
    if (wide) begin
      if (b == '0 || (sg && a == MIN128 && b == '1)) begin
        r = a; lat = 0;
      end else begin
        if (sg) begin
          logic signed [255:0] n, d, q;
          n = $signed({a, 128'b0});
          d = $signed({{128{b[127]}}, b});
          q = n / d;
          r = q[127:0];
        end else begin
          logic [255:0] n, d, q;
          n = {a, 128'b0};
          d = {128'b0, b};
          q = n / d;
          r = q[127:0];
        end
        lat = 256;
      end
    end else begin
      int nspec = 0;
      for (int l = 0; l < 2; l++) begin
        logic [63:0] ae, be;
        ae = a[l*64 +: 64];
        be = b[l*64 +: 64];
        if (be == '0 || (sg && ae == MIN64 && be == '1)) begin
          r[l*64 +: 64] = ae; nspec++;
        end else if (sg) begin
          logic signed [127:0] n, d, q;
          n = $signed({ae, 64'b0});
          d = $signed({{64{be[63]}}, be});
          q = n / d;
          r[l*64 +: 64] = q[63:0];
        end else begin
          logic [127:0] n, d, q;
          n = {ae, 64'b0};
          d = {64'b0, be};
          q = n / d;
          r[l*64 +: 64] = q[63:0];
        end
      end
      lat = (nspec == 2) ? 0 : 128;
    end
    return r;
  endfunction

  task automatic run_op(input string req, input logic [10:0] c, input logic [127:0] a,
                        input logic [127:0] b, input bit poke);
    logic [127:0] exp;
    int lat;
    bit ok;
    exp = model(mk(c), a, b, lat);
    @(negedge clk);
    in_valid = 1'b1; insn = mk(c); opa = a; opb = b;
    @(negedge clk);
    in_valid = 1'b0;
    ok = (busy === 1'b1) && (done === 1'b0);
    for (int k = 0; k < lat; k++) begin
      if (poke && k == 3) begin
        in_valid = 1'b1; insn = mk(C_U64); opa = '1; opb = 128'd7;
      end
      @(negedge clk);
      in_valid = 1'b0;
      if (busy !== 1'b1 || done !== 1'b0 || in_ready !== 1'b0) ok = 1'b0;
    end
    @(negedge clk);
    ok = ok && (done === 1'b1) && (busy === 1'b0) && (in_ready === 1'b1);
    check(ok, {req, " R10 R11 timing done"}, {127'b0, done}, 128'd1);
    check(result === exp, {req, " value"}, result, exp);
    @(negedge clk);
    check(done === 1'b0, {req, " R10 done pulse"}, {127'b0, done}, 128'd0);
  endtask

  task automatic run_bad(input string req, input logic [31:0] w);
    logic [127:0] prev;
    bit ok;
    prev = result;
    @(negedge clk);
    in_valid = 1'b1; insn = w; opa = 128'h55; opb = 128'h3;
    @(negedge clk);
    in_valid = 1'b0;
    ok = 1'b1;
    for (int k = 0; k < 4; k++) begin
      if (busy !== 1'b0 || done !== 1'b0) ok = 1'b0;
      @(negedge clk);
    end
    check(ok, {req, " R1 illegal stays idle"}, {126'b0, busy, done}, 128'd0);
    check(result === prev, {req, " R1 result unchanged"}, result, prev);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL R10 watchdog: cycles=%0d expected<=100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && in_ready === 1'b1, "R12 reset flags",
          {125'b0, busy, done, in_ready}, 128'd1);
    check(result === '0, "R12 reset result", result, '0);

    run_op("R2 R8 u64 small/overflow", C_U64, {64'd7, 64'd5}, {64'd3, 64'd1000}, 0);
    run_op("R2 u64 mixed", C_U64, {64'h0123_4567_89ab_cdef, 64'h1},
           {64'hffff_ffff_ffff_ffff, 64'h2}, 0);
    run_op("R3 s64 mixed signs", C_S64, {-64'sd5, 64'sd5}, {64'sd3, -64'sd7}, 0);
    run_op("R3 s64 both negative", C_S64, {-64'sd100, -64'sd1}, {-64'sd7, -64'sd3}, 0);
    run_op("R4 u128 small", C_U128, 128'd1, 128'd3, 0);
    run_op("R4 R8 u128 large", C_U128, {64'hdead_beef_0bad_f00d, 64'h1234},
           {64'h0, 64'h0fff_0000_0000_0001}, 0);
    run_op("R5 s128 mixed", C_S128, -128'sd12345, 128'sd1000000007, 0);
    run_op("R5 R8 s128 min by 3", C_S128, MIN128, 128'd3, 0);
    run_op("R6 R9 s64 lane0 zero divisor", C_S64, {64'd9, 64'h77}, {64'd4, 64'd0}, 0);
    run_op("R6 R10 u64 both zero", C_U64, {64'h11, 64'h22}, 128'd0, 0);
    run_op("R7 R9 s64 lane1 min/-1", C_S64, {MIN64, 64'd10}, {64'hffff_ffff_ffff_ffff, 64'd3}, 0);
    run_op("R7 u64 min/all-ones divides", C_U64, {MIN64, MIN64}, '1, 0);
    run_op("R7 R10 s128 min/-1", C_S128, MIN128, '1, 0);
    run_op("R6 u128 zero divisor", C_U128, 128'hcafe, 128'd0, 0);
    run_op("R11 request while busy", C_U128, 128'd1000, 128'd7, 1);

    run_bad("R1 bad primary", {6'b000101, 15'd0, C_U64});
    run_bad("R1 bad extended", {6'b000100, 15'h1234, 11'b01111001010});

    run_op("R1 fields ignored", C_S64, {64'd50, -64'sd50}, {64'd6, 64'd6}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule